// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Counter

This block is one down-counting timer channel. It has a preset register, a mode register and a single waveform output. Counting moves forward only on system-clock cycles where the count enable is high, so a slow count clock is supplied as an enable pulse train in the system clock domain. Software, or surrounding logic, writes a preset through a write strobe and picks one of six output behaviours through a mode write. Depending on the mode, counting starts on the preset write itself or on a rising edge of the trigger input.

The six behaviours are:

- a level that rises at terminal count;
- a retriggerable one-shot low pulse;
- a periodic one-tick low strobe (rate generator);
- a square wave;
- a one-tick strobe started by the preset write;
- a one-tick strobe started by the trigger.

The live count is visible on an output at all times. A preset of zero stands for the largest count, 2^CNT_W.

Top module: `pic_top`

## Requirements
- R1: After synchronous reset the mode is terminal-count (code 0), `wave_out` is 0 and `count_val` is 0.
- R2: A mode write takes `mode_sel`: 0 terminal-count, 1 one-shot, 2 rate, 3 square, 4 software strobe, 5 hardware strobe, 6 acts as 2, 7 acts as 3. On the next cycle `wave_out` is 0 for mode 0 and 1 for every other mode, and counting is halted until that mode's start condition.
- R3: Terminal-count mode: a preset write loads the count and drives the output low. After preset enabled ticks the count reaches 0 and the output goes high. It stays high, with counting stopped, until the next preset write.
- R4: One-shot mode: a preset write only stores the value. Each trigger rising edge loads the stored preset and drives the output low, including an edge that arrives mid-count, which restarts the pulse. The output returns high when the count reaches 0 and holds until the next edge.
- R5: Rate mode (preset ≥ 2): a preset write starts counting with the output high. When the count steps from 2 to 1 the output goes low. On the next enabled tick the preset is reloaded and the output goes high. The period is preset ticks.
- R6: Square mode with an even preset: a preset write loads the preset with the output high. The count drops by 2 per enabled tick. When it would reach 0, the preset is reloaded and the output toggles, giving preset/2 ticks per half-period.
- R7: Square mode with an odd preset ≥ 3: the count is loaded with preset−1 and drops by 2. While the output is high, the output goes low one tick after the count hits 0, and preset−1 is reloaded. While the output is low, the output goes high when the count would reach 0, again with a reload. High lasts (preset+1)/2 ticks and low lasts (preset−1)/2 ticks.
- R8: Software strobe mode: a preset write loads the count with the output high. When the count reaches 0 the output goes low for one enabled tick, then returns high and counting stops.
- R9: Hardware strobe mode: a preset write only stores the value. A trigger rising edge loads the stored preset and starts counting. At count 0 the output goes low for one enabled tick, then returns high and counting stops.
- R10: Only a rising edge of `trig_in` (low in the previous cycle, high now) starts or restarts counting, and only in modes 1 and 5. In the other modes the trigger has no effect, and a held-high trigger does not retrigger.
- R11: While `cnt_en` is low, neither the count nor the output changes, except through a preset write, a mode write or a trigger edge.
- R12: A preset of 0 counts as 2^CNT_W enabled ticks.
- R13: `count_val` always shows the low CNT_W bits of the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable; one tick per high cycle |
| trig_in | input | 1 | Trigger input, rising-edge sensitive |
| preset_wr | input | 1 | Preset write strobe |
| preset_data | input | CNT_W | Preset value written on `preset_wr` |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode code written on `mode_wr` |
| wave_out | output | 1 | Registered waveform output |
| count_val | output | CNT_W | Current count, low CNT_W bits |

## Verification
The bench builds the block with CNT_W = 8. This keeps the zero-preset maximum count of 256 within a short directed run, so the full-range wrap and the terminal transition at 2^CNT_W are checked tick by tick. Small presets, both odd and even, give many complete square-wave and rate periods in a short random run. They also let retriggers land mid-count in the one-shot and hardware strobe modes.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    MODE_TC      = 3'd0,
    MODE_ONESHOT = 3'd1,
    MODE_RATE    = 3'd2,
    MODE_SQUARE  = 3'd3,
    MODE_SWSTB   = 3'd4,
    MODE_HWSTB   = 3'd5
  } pic_mode_e;

  // Codes 6 and 7 alias the two periodic modes
  function automatic pic_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd6:    return MODE_RATE;
      3'd7:    return MODE_SQUARE;
      default: return pic_mode_e'(code);
    endcase
  endfunction

  function automatic logic idle_level(input pic_mode_e m);
    return (m != MODE_TC);
  endfunction

  function automatic logic starts_on_write(input pic_mode_e m);
    return (m == MODE_TC) || (m == MODE_RATE) || (m == MODE_SQUARE) || (m == MODE_SWSTB);
  endfunction

  function automatic logic starts_on_trigger(input pic_mode_e m);
    return (m == MODE_ONESHOT) || (m == MODE_HWSTB);
  endfunction

endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;

endmodule

// File: rtl/pic_preset_reg.sv
module pic_preset_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W:0]   new_eff,
  output logic [CNT_W:0]   held_eff,
  output logic             held_odd
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] MAXC = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W-1:0] preset_q;

  always_ff @(posedge clk) begin
    if (rst)     preset_q <= '0;
    else if (wr) preset_q <= wdata;
  end

  // A zero preset stands for the full range
  assign new_eff  = (wdata == '0)    ? MAXC : {1'b0, wdata};
  assign held_eff = (preset_q == '0) ? MAXC : {1'b0, preset_q};
  assign held_odd = preset_q[0];

endmodule

// File: rtl/pic_counter_core.sv
module pic_counter_core
  import pic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_en,
  input  logic           rise,
  input  logic           load_stb,
  input  logic [CNT_W:0] new_eff,
  input  logic [CNT_W:0] held_eff,
  input  logic           held_odd,
  input  logic           mode_wr,
  input  logic [2:0]     mode_sel,
  output logic           out_q,
  output logic [CNT_W:0] cnt_q
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);
  localparam logic [CW-1:0] MAXC = {1'b1, {CNT_W{1'b0}}};

  pic_mode_e mode_q;
  logic      run_q;
  logic [CW-1:0] sq_reload;

  assign sq_reload = {held_eff[CW-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_TC;
      out_q  <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (mode_wr) begin
      mode_q <= decode_mode(mode_sel);
      out_q  <= idle_level(decode_mode(mode_sel));
      run_q  <= 1'b0;
    end else if (load_stb) begin
      if (starts_on_write(mode_q)) begin
        cnt_q <= (mode_q == MODE_SQUARE) ? {new_eff[CW-1:1], 1'b0} : new_eff;
        run_q <= 1'b1;
        out_q <= idle_level(mode_q);
      end
    end else if (rise && starts_on_trigger(mode_q)) begin
      cnt_q <= held_eff;
      run_q <= 1'b1;
      out_q <= (mode_q != MODE_ONESHOT);
    end else if (cnt_en && run_q) begin
      case (mode_q)
        MODE_TC, MODE_ONESHOT: begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end
        end
        MODE_RATE: begin
          if (cnt_q == ONE) begin
            cnt_q <= held_eff;
            out_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == TWO) out_q <= 1'b0;
          end
        end
        MODE_SQUARE: begin
          if (cnt_q == TWO && (!out_q || !held_odd)) begin
            cnt_q <= sq_reload;
            out_q <= ~out_q;
          end else if (out_q && held_odd && cnt_q == '0) begin
            cnt_q <= sq_reload;
            out_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - TWO;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) out_q <= 1'b0;
          end
        end
      endcase
    end
  end

  // R2
  mode_level_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (out_q == ($past(mode_sel) != 3'd0)) && !run_q);

  // R3
  tc_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TC && out_q) |-> (cnt_q == '0 && !run_q));

  // R5
  rate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RATE && !out_q) |-> (cnt_q == ONE));

  // R6
  square_even_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SQUARE && run_q) |-> !cnt_q[0]);

  // R8
  strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MODE_SWSTB || mode_q == MODE_HWSTB) && !out_q) |-> (cnt_q == '0 && run_q));

  // R12
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAXC);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !mode_wr && !load_stb && !rise) |=> $stable(cnt_q) && $stable(out_q));

endmodule

// File: rtl/pic_top.sv
module pic_top #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             trig_in,
  input  logic             preset_wr,
  input  logic [CNT_W-1:0] preset_data,
  input  logic             mode_wr,
  input  logic [2:0]       mode_sel,
  output logic             wave_out,
  output logic [CNT_W-1:0] count_val
);
  logic           trig_rise;
  logic [CNT_W:0] new_eff;
  logic [CNT_W:0] held_eff;
  logic           held_odd;
  logic [CNT_W:0] cnt_full;

  pic_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (trig_in),
    .rise (trig_rise)
  );

  pic_preset_reg #(.CNT_W(CNT_W)) u_preset (
    .clk      (clk),
    .rst      (rst),
    .wr       (preset_wr),
    .wdata    (preset_data),
    .new_eff  (new_eff),
    .held_eff (held_eff),
    .held_odd (held_odd)
  );

  pic_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .rise     (trig_rise),
    .load_stb (preset_wr),
    .new_eff  (new_eff),
    .held_eff (held_eff),
    .held_odd (held_odd),
    .mode_wr  (mode_wr),
    .mode_sel (mode_sel),
    .out_q    (wave_out),
    .cnt_q    (cnt_full)
  );

  // R13
  assign count_val = cnt_full[CNT_W-1:0];

endmodule

// File: tb/tb_pic_top.sv
module tb_pic_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MAXV = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, trig_in = 1'b0, preset_wr = 1'b0, mode_wr = 1'b0;
  logic [W-1:0] preset_data = '0;
  logic [2:0] mode_sel = '0;
  logic wave_out;
  logic [W-1:0] count_val;

  int checks = 0, failures = 0, cycles = 0;
  string tag_over = "";

  // reference state
  int m_mode, m_pre, m_cnt;
  bit m_out, m_run, m_gprev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_top #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .trig_in(trig_in),
    .preset_wr(preset_wr), .preset_data(preset_data),
    .mode_wr(mode_wr), .mode_sel(mode_sel),
    .wave_out(wave_out), .count_val(count_val)
  );

  function automatic string tag_of();
    case (m_mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return (m_pre % 2 == 1) ? "R7" : "R6";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_pre = 0; m_cnt = 0; m_out = 0; m_run = 0; m_gprev = 0;
  endtask

  task automatic model_step(input bit en, input bit g, input bit ld, input int d,
                            input bit mw, input int ms);
    bit rise;
    int eff;
    rise = g && !m_gprev;
    m_gprev = g;
    if (mw) begin
      m_mode = (ms == 6) ? 2 : (ms == 7) ? 3 : ms;
      m_out = (m_mode != 0);
      m_run = 0;
    end else if (ld) begin
      m_pre = d;
      if (m_mode == 0 || m_mode == 2 || m_mode == 3 || m_mode == 4) begin
        eff = (d == 0) ? MAXV : d;
        m_cnt = (m_mode == 3) ? (eff - eff % 2) : eff;
        m_run = 1;
        m_out = (m_mode != 0);
      end
    end else if (rise && (m_mode == 1 || m_mode == 5)) begin
      m_cnt = (m_pre == 0) ? MAXV : m_pre;
      m_run = 1;
      m_out = (m_mode == 5);
    end else if (en && m_run) begin
      eff = (m_pre == 0) ? MAXV : m_pre;
      case (m_mode)
        0, 1: begin
          m_cnt--;
          if (m_cnt == 0) begin m_out = 1; m_run = 0; end
        end
        2: begin
          m_cnt--;
          if (m_cnt == 1) m_out = 0;
          if (m_cnt == 0) begin m_cnt = eff; m_out = 1; end
        end
        3: begin
          if (eff % 2 == 1 && m_out && m_cnt == 0) begin
            m_out = 0; m_cnt = eff - 1;
          end else begin
            m_cnt -= 2;
            if (m_cnt == 0 && !(eff % 2 == 1 && m_out)) begin
              m_cnt = eff - eff % 2;
              m_out = !m_out;
            end
          end
        end
        default: begin
          if (!m_out) begin m_out = 1; m_run = 0; end
          else begin
            m_cnt--;
            if (m_cnt == 0) m_out = 0;
          end
        end
      endcase
    end
  endtask

  // Called at a falling edge; drives inputs, steps the model, compares at the next falling edge
  task automatic tick(input bit en, input bit ld, input int d, input bit mw, input int ms);
    string t;
    cnt_en = en; preset_wr = ld; preset_data = W'(d); mode_wr = mw; mode_sel = 3'(ms);
    @(posedge clk);
    model_step(en, trig_in, ld, d, mw, ms);
    @(negedge clk);
    cnt_en = 0; preset_wr = 0; mode_wr = 0;
    t = (tag_over != "") ? tag_over : tag_of();
    check_eq(t, int'(wave_out), int'(m_out), "wave_out");
    check_eq(t, int'(count_val), m_cnt % MAXV, "count_val");
  endtask

  task automatic run(input int n, input bit en);
    for (int i = 0; i < n; i++) tick(en, 0, 0, 0, 0);
  endtask

  task automatic set_mode(input int ms);
    tick(0, 0, 0, 1, ms);
  endtask

  task automatic load(input int d);
    tick(0, 1, d, 0, 0);
  endtask

  task automatic trig_pulse();
    trig_in = 1; tick(1, 0, 0, 0, 0);
    trig_in = 0; tick(1, 0, 0, 0, 0);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int keep;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check_eq("R1", int'(wave_out), 0, "wave_out after reset");
    check_eq("R1", int'(count_val), 0, "count_val after reset");

    // R12 R13: full-range count in terminal-count mode
    tag_over = "R12";
    load(0);
    run(MAXV - 1, 1);
    check_eq("R13", int'(count_val), 1, "count one tick before terminal");
    run(1, 1);
    check_eq("R12", int'(wave_out), 1, "high after 2^W ticks");
    run(4, 1);
    tag_over = "";

    // R3 terminal count, reload drives low again
    load(5); run(7, 1); load(3); run(5, 1);

    // R2 mode levels and aliases
    tag_over = "R2";
    set_mode(4);
    check_eq("R2", int'(wave_out), 1, "strobe mode idle level");
    set_mode(0);
    check_eq("R2", int'(wave_out), 0, "terminal mode idle level");
    set_mode(6); load(4); run(10, 1);
    set_mode(7); load(6); run(10, 1);
    tag_over = "";

    // R11 enable gating
    set_mode(2); load(5);
    keep = int'(count_val);
    tag_over = "R11";
    run(8, 0);
    check_eq("R11", int'(count_val), keep, "count held without enable");
    tag_over = "";

    // R5 rate generator
    run(16, 1);
    // R6 square even, R7 square odd
    set_mode(3); load(8); run(24, 1);
    load(7); run(24, 1);
    load(3); run(12, 1);
    // R8 software strobe
    set_mode(4); load(4); run(8, 1);
    // R4 one-shot with retrigger
    set_mode(1); load(6); run(3, 1);
    trig_pulse(); run(3, 1);
    trig_pulse(); run(10, 1);
    // R9 hardware strobe with retrigger
    set_mode(5); load(5); run(3, 1);
    trig_pulse(); run(2, 1); trig_pulse(); run(10, 1);

    // R10 held trigger and ignored trigger in rate mode
    tag_over = "R10";
    set_mode(1); load(4);
    trig_in = 1; run(10, 1);
    check_eq("R10", int'(wave_out), 1, "held trigger no retrigger");
    trig_in = 0;
    set_mode(2); load(5);
    trig_pulse(); trig_pulse(); run(6, 1);
    set_mode(0); load(6); trig_pulse(); run(6, 1);
    tag_over = "";

    // Random segments
    for (int s = 0; s < 40; s++) begin
      int ms, p;
      ms = $urandom % 8;
      set_mode(ms);
      p = (ms == 2 || ms == 3 || ms >= 6) ? 2 + $urandom % 16 : 1 + $urandom % 16;
      load(p);
      for (int c = 0; c < 50; c++) begin
        if ($urandom % 5 == 0) trig_in = ~trig_in;
        if ($urandom % 40 == 0) tick(1, 1, p, 0, 0);
        else tick(($urandom % 4) != 0, 0, 0, 0, 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule